// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block produces the status word that a flash device returns on reads while an internal program or erase runs or is suspended. It also drives a ready/busy line. The embedded-algorithm sequencer sends it four things: when an operation starts, which sectors take part, when a further sector is added to an erase, and when the operation finishes. From these and each read strobe it builds the polling, toggle, timeout and erase-window bits. It also tells the read path whether a read should go to the cell array instead of receiving status.

A program operation polls with the complement of the bit-7 data value. If the program targets a protected sector, polling shows only for a short hold period, after which the block returns to read mode by itself. Erases track a per-sector selection mask. After a sector erase starts, further sectors may be added inside an acceptance window counted in clock cycles. The window bit reports when that window has closed. A suspended erase still answers status reads for its selected sectors and hands reads of all other sectors to the array.

Top module: `emb_status`

## Requirements
- R1: After reset `rdy` is 1, `resp_vld` is 0, and a read strobe gives a response with `resp_array` = 1 and `resp_word` = 0.
- R2: While a program to an unprotected sector runs and `susp` is low, a read response has bit 7 equal to the inverse of the latched `op_bit7`. Once `op_done` ends the program, or while `susp` is high, reads are handed to the array.
- R3: A program (`op_kind` = 0) whose sector is set in `prot_mask` polls for `PROT_CYC` cycles with `rdy` low, ignores `op_done`, and then returns to idle by itself.
- R4: Bit 6 starts at 0 with each accepted operation. It alternates on every status read while an operation is active and not suspended.
- R5: Bit 6 holds its value on reads made while `susp` is high or while `tmo` is high.
- R6: Bit 2 alternates on each read of a sector in the erase mask, both while the erase is active and while it is suspended. On a read of any other sector it reads 0.
- R7: During an erase, bit 7 reads 0 while active and 1 on a suspended read of a selected sector. After `op_done`, reads are handed to the array.
- R8: Bit 3 reads 0 until `WIN_CYC` cycles have passed since the last accepted sector-erase or add command, and 1 after that. A chip erase (`op_kind` = 2) reads 1 from the start.
- R9: `op_add` selects `op_sector` only during a sector erase (`op_kind` = 1), while the window is open and `susp` is low, and only when that sector is not in `prot_mask`. An accepted add restarts the window.
- R10: A chip erase selects exactly the sectors that are clear in `prot_mask`.
- R11: Bit 5 of every status response equals `tmo` in the cycle of the read strobe.
- R12: `rdy` is high in idle and low from an accepted `op_go` until completion, except while `susp` is high during a program or erase.
- R13: A response appears in the cycle after `rd_stb`. Bits 4, 1 and 0 are always 0, and an array response carries an all-zero word.
- R14: `op_go` is ignored unless the block is idle, and `op_kind` = 3 is always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_go | input | 1 | Start pulse for an operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 unused |
| op_sector | input | SW | Target sector for `op_go` and `op_add` |
| op_bit7 | input | 1 | Bit 7 of the word being programmed |
| op_add | input | 1 | Add `op_sector` to a running sector erase |
| op_done | input | 1 | Sequencer reports completion |
| susp | input | 1 | Operation is suspended |
| tmo | input | 1 | Operation exceeded its time limit |
| prot_mask | input | NSECT | One bit per protected sector |
| rd_stb | input | 1 | Read strobe |
| rd_sector | input | SW | Sector of the read address |
| rdy | output | 1 | 1 = ready, 0 = busy |
| resp_vld | output | 1 | Read response valid |
| resp_array | output | 1 | Read must be served from the array |
| resp_word | output | 8 | Status word |

## Verification
The bench builds the block with eight sectors, an eight-cycle add window and a five-cycle protected-program hold. These values make window expiry, window restart, late adds and the self-ending protected hold reachable in a few dozen cycles. Sectors 0 and 7 are protected, so both the add filter and the chip-erase mask run into protected entries.

// File: rtl/es_pkg.sv
package es_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_ERASE = 2'd3
    } es_state_e;

    localparam logic [1:0] OP_PROG = 2'd0;
    localparam logic [1:0] OP_SECT = 2'd1;
    localparam logic [1:0] OP_CHIP = 2'd2;

    localparam int POLL_BIT = 7;
    localparam int TOG1_BIT = 6;
    localparam int TMO_BIT  = 5;
    localparam int WIN_BIT  = 3;
    localparam int TOG2_BIT = 2;

endpackage

// File: rtl/es_win_timer.sv
module es_win_timer #(
    parameter int WIN_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_long,
    input  logic load_zero,
    output logic closed
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_long) begin
            cnt_d = CW'(WIN_CYC);
        end else if (load_zero) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign closed = (cnt_q == '0);
endmodule

// File: rtl/es_sect_mask.sv
module es_sect_mask #(
    parameter int NSECT = 16,
    localparam int SW = $clog2(NSECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_new,
    input  logic             ld_all,
    input  logic             add_one,
    input  logic [SW-1:0]    sect,
    input  logic [NSECT-1:0] prot_mask,
    output logic [NSECT-1:0] mask
);
    logic [NSECT-1:0] mask_d, mask_q, one_hot;

    always_comb begin
        one_hot       = '0;
        one_hot[sect] = 1'b1;
        mask_d        = mask_q;
        if (ld_new) begin
            mask_d = ld_all ? ~prot_mask : (one_hot & ~prot_mask);
        end else if (add_one) begin
            mask_d = mask_q | (one_hot & ~prot_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
endmodule

// File: rtl/es_toggle.sv
module es_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip_a,
    input  logic flip_b,
    output logic tog_a,
    output logic tog_b
);
    typedef struct packed {
        logic a;
        logic b;
    } tog_t;

    tog_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (flip_a) d.a = ~q.a;
            if (flip_b) d.b = ~q.b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tog_a = q.a;
    assign tog_b = q.b;
endmodule

// File: rtl/emb_status.sv
module emb_status
    import es_pkg::*;
#(
    parameter int NSECT    = 16,
    parameter int WIN_CYC  = 5000,
    parameter int PROT_CYC = 100,
    localparam int SW = $clog2(NSECT),
    localparam int HW = $clog2(PROT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_go,
    input  logic [1:0]       op_kind,
    input  logic [SW-1:0]    op_sector,
    input  logic             op_bit7,
    input  logic             op_add,
    input  logic             op_done,
    input  logic             susp,
    input  logic             tmo,
    input  logic [NSECT-1:0] prot_mask,
    input  logic             rd_stb,
    input  logic [SW-1:0]    rd_sector,
    output logic             rdy,
    output logic             resp_vld,
    output logic             resp_array,
    output logic [7:0]       resp_word
);
    typedef struct packed {
        es_state_e   st;
        logic        is_chip;
        logic        b7;
        logic [HW-1:0] hold;
        logic        rv;
        logic        ra;
        logic [7:0]  rw;
    } regs_t;

    regs_t d, q;

    logic [NSECT-1:0] mask;
    logic win_closed, win_load, win_zero;
    logic tog1, tog2, flip1, flip2;
    logic go_ok, add_ok, rd_sel, active, susp_eff;
    logic [1:0] st_bits;

    es_sect_mask #(.NSECT(NSECT)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .ld_new(go_ok), .ld_all(op_kind == OP_CHIP), .add_one(add_ok),
        .sect(op_sector), .prot_mask(prot_mask), .mask(mask)
    );

    es_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n),
        .load_long(win_load), .load_zero(win_zero), .closed(win_closed)
    );

    es_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .clr(go_ok),
        .flip_a(flip1), .flip_b(flip2), .tog_a(tog1), .tog_b(tog2)
    );

    always_comb begin
        d        = q;
        rd_sel   = mask[rd_sector];
        active   = (q.st != ST_IDLE);
        susp_eff = susp && (q.st == ST_PROG || q.st == ST_ERASE);
        go_ok    = op_go && (q.st == ST_IDLE) && (op_kind != 2'd3);
        add_ok   = op_add && (q.st == ST_ERASE) && !q.is_chip && !win_closed
                   && !susp && !op_done;
        win_load = (go_ok && op_kind == OP_SECT) || add_ok;
        win_zero = go_ok && (op_kind != OP_SECT);
        flip1    = rd_stb && active && !susp_eff && !tmo;
        flip2    = rd_stb && (q.st == ST_ERASE) && rd_sel;

        // read response, one cycle after the strobe
        d.rv = rd_stb;
        d.ra = 1'b1;
        d.rw = '0;
        if (rd_stb) begin
            if ((q.st == ST_PROG && !susp) || q.st == ST_HOLD) begin
                d.ra           = 1'b0;
                d.rw[POLL_BIT] = ~q.b7;
                d.rw[TOG1_BIT] = tog1;
                d.rw[TMO_BIT]  = tmo;
            end else if (q.st == ST_ERASE && (!susp || rd_sel)) begin
                d.ra           = 1'b0;
                d.rw[POLL_BIT] = susp;
                d.rw[TOG1_BIT] = tog1;
                d.rw[TMO_BIT]  = tmo;
                d.rw[WIN_BIT]  = win_closed;
                d.rw[TOG2_BIT] = rd_sel && tog2;
            end
        end

        // operation state
        unique case (q.st)
            ST_IDLE: begin
                if (go_ok) begin
                    d.b7      = op_bit7;
                    d.is_chip = (op_kind == OP_CHIP);
                    if (op_kind == OP_PROG) begin
                        if (prot_mask[op_sector]) begin
                            d.st   = ST_HOLD;
                            d.hold = HW'(PROT_CYC);
                        end else begin
                            d.st = ST_PROG;
                        end
                    end else begin
                        d.st = ST_ERASE;
                    end
                end
            end
            ST_PROG, ST_ERASE: begin
                if (op_done) d.st = ST_IDLE;
            end
            ST_HOLD: begin
                if (q.hold <= HW'(1)) d.st = ST_IDLE;
                else                  d.hold = q.hold - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ra <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign st_bits    = q.st;
    assign rdy        = (q.st == ST_IDLE) || susp_eff;
    assign resp_vld   = q.rv;
    assign resp_array = q.ra;
    assign resp_word  = q.rw;
endmodule

// File: rtl/emb_status_chk.sv
module emb_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_go,
    input logic [1:0] op_kind,
    input logic       tmo,
    input logic       rd_stb,
    input logic       rdy,
    input logic       resp_vld,
    input logic       resp_array,
    input logic [7:0] resp_word,
    input logic [1:0] st_bits,
    input logic       rd_sel,
    input logic       win_closed,
    input logic       win_load
);
    p_resp_lat_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> resp_vld);

    p_resp_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !resp_vld);

    p_zero_bits_r13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> (resp_word[4] == 1'b0 && resp_word[1:0] == 2'b00));

    p_array_blank_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_array) |-> (resp_word == 8'h00));

    p_tmo_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st_bits != 2'd0) |=> (resp_array || resp_word[5] == $past(tmo)));

    p_idle_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_bits == 2'd0) |-> rdy);

    p_go_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_bits == 2'd0 && op_go && op_kind != 2'd3) |=> (st_bits != 2'd0));

    p_tog2_unsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_sel) |=> (resp_array || !resp_word[2]));

    p_win_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_closed) |-> $past(win_load));
endmodule

bind emb_status emb_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_kind(op_kind), .tmo(tmo),
    .rd_stb(rd_stb), .rdy(rdy), .resp_vld(resp_vld), .resp_array(resp_array),
    .resp_word(resp_word), .st_bits(st_bits), .rd_sel(rd_sel),
    .win_closed(win_closed), .win_load(win_load)
);

// File: tb/emb_status_bench.sv
module emb_status_bench;
    localparam int NS   = 8;
    localparam int WIN  = 8;
    localparam int PROT = 5;
    localparam int SW   = $clog2(NS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_go = 0, op_bit7 = 0, op_add = 0, op_done = 0, susp = 0, tmo = 0, rd_stb = 0;
    logic [1:0] op_kind = 0;
    logic [SW-1:0] op_sector = 0, rd_sector = 0;
    logic [NS-1:0] prot_mask = 8'b1000_0001;
    logic rdy, resp_vld, resp_array;
    logic [7:0] resp_word;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    emb_status #(.NSECT(NS), .WIN_CYC(WIN), .PROT_CYC(PROT)) u_emb_status (
        .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_kind(op_kind),
        .op_sector(op_sector), .op_bit7(op_bit7), .op_add(op_add),
        .op_done(op_done), .susp(susp), .tmo(tmo), .prot_mask(prot_mask),
        .rd_stb(rd_stb), .rd_sector(rd_sector), .rdy(rdy), .resp_vld(resp_vld),
        .resp_array(resp_array), .resp_word(resp_word)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle, 1 program, 2 hold, 3 erase
    int m_st = 0, m_chip = 0, m_b7 = 0, m_hold = 0, m_win = 0, m_t1 = 0, m_t2 = 0;
    int m_rv = 0, m_ra = 1, m_rw = 0;
    bit m_mask [NS];

    always @(posedge clk) begin : model
        int sel, cl, act, se, nrv, nra, nrw, f1, f2, go, add, exp_rdy;
        if (!rst_n) begin
            m_st = 0; m_chip = 0; m_b7 = 0; m_hold = 0; m_win = 0;
            m_t1 = 0; m_t2 = 0; m_rv = 0; m_ra = 1; m_rw = 0;
            foreach (m_mask[i]) m_mask[i] = 0;
        end else begin
            sel = m_mask[rd_sector];
            cl  = (m_win == 0);
            act = (m_st != 0);
            se  = susp && (m_st == 1 || m_st == 3);
            nrv = rd_stb; nra = 1; nrw = 0;
            if (rd_stb) begin
                if ((m_st == 1 && !susp) || m_st == 2) begin
                    nra = 0;
                    nrw = (m_b7 ? 0 : 128) + (m_t1 ? 64 : 0) + (tmo ? 32 : 0);
                end else if (m_st == 3 && (!susp || sel)) begin
                    nra = 0;
                    nrw = (susp ? 128 : 0) + (m_t1 ? 64 : 0) + (tmo ? 32 : 0)
                        + (cl ? 8 : 0) + ((sel && m_t2) ? 4 : 0);
                end
            end
            f1  = rd_stb && act && !se && !tmo;
            f2  = rd_stb && m_st == 3 && sel;
            go  = op_go && m_st == 0 && op_kind != 3;
            add = op_add && m_st == 3 && !m_chip && !cl && !susp && !op_done;
            if (go) begin
                m_t1 = 0; m_t2 = 0;
            end else begin
                if (f1) m_t1 = 1 - m_t1;
                if (f2) m_t2 = 1 - m_t2;
            end
            if (go)            m_win = (op_kind == 1) ? WIN : 0;
            else if (add)      m_win = WIN;
            else if (m_win > 0) m_win = m_win - 1;
            if (go) begin
                for (int i = 0; i < NS; i++)
                    m_mask[i] = (op_kind == 2) ? !prot_mask[i] : (i == op_sector && !prot_mask[i]);
            end else if (add && !prot_mask[op_sector]) begin
                m_mask[op_sector] = 1;
            end
            case (m_st)
                0: if (go) begin
                    m_b7 = op_bit7; m_chip = (op_kind == 2);
                    if (op_kind == 0) begin
                        if (prot_mask[op_sector]) begin m_st = 2; m_hold = PROT; end
                        else m_st = 1;
                    end else m_st = 3;
                end
                1, 3: if (op_done) m_st = 0;
                2: if (m_hold <= 1) m_st = 0; else m_hold = m_hold - 1;
                default: m_st = 0;
            endcase
            m_rv = nrv; m_ra = nra; m_rw = nrw;
        end
        #1;
        if (rst_n && !finished) begin
            exp_rdy = (m_st == 0) || (susp && (m_st == 1 || m_st == 3));
            chk("R12 rdy", rdy, exp_rdy);
            chk("R13 resp_vld", resp_vld, m_rv);
            chk("R2 resp_array", resp_array, m_ra);
            chk("R7 poll bit", resp_word[7], (m_rw >> 7) & 1);
            chk("R4 toggle I", resp_word[6], (m_rw >> 6) & 1);
            chk("R11 timeout bit", resp_word[5], (m_rw >> 5) & 1);
            chk("R8 window bit", resp_word[3], (m_rw >> 3) & 1);
            chk("R6 toggle II", resp_word[2], (m_rw >> 2) & 1);
            chk("R13 spare bits", {resp_word[4], resp_word[1:0]}, 0);
        end
    end

    task automatic go(input int kind, input int s, input bit b7);
        @(negedge clk); op_go = 1; op_kind = 2'(kind); op_sector = SW'(s); op_bit7 = b7;
        @(negedge clk); op_go = 0;
    endtask
    task automatic add(input int s);
        @(negedge clk); op_add = 1; op_sector = SW'(s);
        @(negedge clk); op_add = 0;
    endtask
    task automatic done();
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
    endtask
    task automatic rd(input int s);
        @(negedge clk); rd_stb = 1; rd_sector = SW'(s);
        @(negedge clk); rd_stb = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        chk("R1 rdy after reset", rdy, 1);
        chk("R1 vld after reset", resp_vld, 0);
        rd(2);
        chk("R1 idle read array", {resp_array, resp_word}, 9'h100);

        // program, unprotected sector, bit7 = 1
        go(0, 2, 1);
        chk("R12 busy", rdy, 0);
        rd(2); chk("R2 first poll", resp_word, 8'h00);
        rd(2); chk("R4 second poll", resp_word, 8'h40);
        tmo = 1;
        rd(2); chk("R11 timeout set", resp_word, 8'h20);
        rd(2); chk("R5 frozen on timeout", resp_word[6], 0);
        tmo = 0;
        susp = 1; idle(1);
        chk("R12 ready in suspend", rdy, 1);
        rd(2); chk("R2 suspend array", resp_array, 1);
        susp = 0;
        rd(2); chk("R5 unchanged after suspend", resp_word[6], 0);
        go(1, 3, 0);
        rd(2); chk("R14 go ignored when busy", resp_word[3], 0);
        done();
        rd(2); chk("R2 done array", resp_array, 1);

        // program to protected sector, bit7 = 0
        go(0, 0, 0);
        chk("R3 busy", rdy, 0);
        rd(0); chk("R3 poll shows", resp_word[7], 1);
        done();
        chk("R3 done ignored", rdy, 0);
        idle(4);
        chk("R3 self return", rdy, 1);

        // sector erase of sector 3
        go(1, 3, 0);
        rd(3); chk("R7 erase poll", resp_word, 8'h00);
        rd(3); chk("R6 toggle II", resp_word, 8'h44);
        rd(4); chk("R6 unselected", resp_word[2], 0);
        add(4);
        add(0);
        idle(WIN + 2);
        rd(3); chk("R8 window closed", resp_word[3], 1);
        add(5);
        susp = 1; idle(1);
        rd(4); chk("R7 suspended sel", {resp_array, resp_word[7]}, 2'b01);
        rd(4); rd(4);
        chk("R5 frozen in suspend", resp_word[6], 0);
        rd(5); chk("R9 late add rejected", resp_array, 1);
        rd(0); chk("R9 protected add rejected", resp_array, 1);
        susp = 0;
        done();
        rd(3); chk("R7 erase done", resp_array, 1);

        // window restart
        go(1, 1, 0);
        idle(4);
        add(2);
        idle(4);
        rd(2); chk("R9 window restarted", resp_word[3], 0);
        rd(2); chk("R9 added sector toggles", resp_word[2], 1);
        done();

        // chip erase
        go(2, 0, 0);
        rd(7); chk("R8 chip window", resp_word[3], 1);
        rd(7); chk("R10 protected not selected", resp_word[2], 0);
        rd(1); rd(1); chk("R10 unprotected selected", resp_word[2], 1);
        done();

        // unused code
        go(3, 2, 0);
        chk("R14 kind 3 ignored", rdy, 1);
        rd(2); chk("R14 still idle", resp_array, 1);
        idle(3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule